// File: doc/BRIEF.md
# Frame-Aligned Synchronous Register Access Window Generator

This block sits beside the processor port of a line-interface controller. Some of that controller's registers share one physical buffer with the serial shifters. Such a register can only be touched safely during a stretch of time after each frame boundary. The block turns an 8 kHz frame pulse into a one-cycle "new data available" strobe, which goes out on a shared interrupt pin. It also turns the same pulse into three access windows of different lengths, one for each class of shared register.

Every processor access comes in tagged with a register class. The block grants the access if the class window is open at the moment of the request and rejects it otherwise. A reject sets a sticky violation flag, and the processor clears that flag by reading it. Mode and formatter registers are not tied to the frame, so accesses to them are always granted. Window lengths are counted in bit-clock cycles. They are derived at elaboration from the bit-clock frequency and from the time limit of each class in nanoseconds (124.75 us, 109.3 us and 62.5 us).

Top module: `nda_access_window`

## Requirements
- R1: While reset is asserted and after it is released, with no frame pulse yet, `nda_irq`, `grant`, `reject` and `viol_flag` are 0 and `win_open` is 3'b000.
- R2: When `frame_pulse` is sampled high at a clock edge after being low at the previous edge, the internal frame strobe is high for exactly the following clock cycle. `nda_irq` carries that strobe when `irq_en` is 1.
- R3: While `irq_en` is 0, `nda_irq` stays 0. The windows still open and close as in R4 to R6.
- R4: `win_open[0]` (class A) is 1 for exactly LEN_A = floor(124750 ns x f_clk) consecutive cycles, starting in the strobe cycle. With the default 2048 kHz clock this is 255 cycles.
- R5: `win_open[1]` (class B) is 1 for exactly LEN_B = floor(109300 ns x f_clk) cycles from the strobe cycle. The default is 223 cycles.
- R6: `win_open[2]` (class C) is 1 for exactly LEN_C = floor(62500 ns x f_clk) cycles from the strobe cycle. The default is 128 cycles.
- R7: A new rising edge of `frame_pulse` restarts all windows from the strobe cycle, even if they are still open. A pulse that is held high for several cycles starts only one strobe.
- R8: A request with `req_class` = 2'b00 (asynchronous register) is granted whatever the window state.
- R9: A request with `req_class` 2'b01 (A), 2'b10 (B) or 2'b11 (C) is granted if `win_open` bit 0, 1 or 2 respectively is 1 in the request cycle. Otherwise it is rejected.
- R10: A reject sets `viol_flag` in the same cycle as the reject pulse. The flag stays set until a cycle with `viol_rd` = 1 clears it at the next edge. If a new reject happens at that same edge, the flag stays set.
- R11: A request sampled at an edge gives exactly one of `grant` or `reject`, as a one-cycle pulse in the cycle after the request. With no request, both stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | 8 kHz frame pulse, active high |
| irq_en | input | 1 | Enables the strobe on the interrupt pin (control bit 2) |
| req_valid | input | 1 | Processor access request |
| req_class | input | 2 | Register class: 00 async, 01 A, 10 B, 11 C |
| viol_rd | input | 1 | Processor read of the violation flag; clears it |
| nda_irq | output | 1 | New-data strobe on the shared interrupt pin |
| win_open | output | 3 | Window open per class: bit0 A, bit1 B, bit2 C |
| grant | output | 1 | Access granted, one-cycle pulse |
| reject | output | 1 | Access rejected, one-cycle pulse |
| viol_flag | output | 1 | Sticky access-violation flag |

## Verification
The assertions check the cycle-local rules on every cycle. These are: the interrupt stays quiet when disabled, the strobe lasts one cycle, all three windows open in the strobe cycle, the windows nest, grant and reject never overlap, each request gets exactly one response, asynchronous requests are always granted, and the violation flag is set and held correctly. The exact window lengths in cycles, the closing cycle at each class boundary, the restart on a mid-window frame pulse and the single strobe for a held pulse span hundreds of cycles. Those are shown by the bench's scenarios, checked against a behavioural frame model and by counting open cycles.

// File: rtl/nda_win_pkg.sv
package nda_win_pkg;

  typedef enum logic [1:0] {
    CLS_ASYNC = 2'b00,
    CLS_A     = 2'b01,
    CLS_B     = 2'b10,
    CLS_C     = 2'b11
  } reg_class_e;

  localparam int NUM_SYNC = 3;

  // Whole bit-clock cycles that fit in a time limit given in nanoseconds.
  function automatic int ns_to_cycles(longint limit_ns, longint clk_khz);
    longint prod;
    prod = limit_ns * clk_khz;
    return int'(prod / 64'd1000000);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // Number of bits needed to hold the value v.
  function automatic int bits_for(int v);
    int w;
    w = 1;
    while ((1 << w) <= v) w++;
    return w;
  endfunction

endpackage

// File: rtl/nda_frame_timer.sv
module nda_frame_timer #(
  parameter int CNT_W     = 8,
  parameter int CNT_LIMIT = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  output logic             frame_strobe,
  output logic [CNT_W-1:0] frame_cnt
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_LIMIT);

  logic fp_q;
  logic fp_rise;

  assign fp_rise = frame_pulse & ~fp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q         <= 1'b0;
      frame_strobe <= 1'b0;
      frame_cnt    <= LIMIT;
    end else begin
      fp_q         <= frame_pulse;
      frame_strobe <= fp_rise;
      if (fp_rise)
        frame_cnt <= '0;
      else if (frame_cnt != LIMIT)
        frame_cnt <= frame_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/nda_window_decode.sv
module nda_window_decode #(
  parameter int                       CNT_W = 8,
  parameter int                       NUM   = 3,
  parameter logic [NUM*CNT_W-1:0]     LENS  = '0
) (
  input  logic [CNT_W-1:0] frame_cnt,
  output logic [NUM-1:0]   win_open
);

  for (genvar k = 0; k < NUM; k++) begin : g_win
    localparam logic [CNT_W-1:0] LEN_K = LENS[k*CNT_W +: CNT_W];
    assign win_open[k] = (frame_cnt < LEN_K);
  end

endmodule

// File: rtl/nda_access_gate.sv
module nda_access_gate
  import nda_win_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_class,
  input  logic                viol_rd,
  input  logic [NUM_SYNC-1:0] win_open,
  output logic                in_window,
  output logic                grant,
  output logic                reject,
  output logic                viol_flag
);

  reg_class_e cls;
  logic       bad_req;

  assign cls = reg_class_e'(req_class);

  always_comb begin
    case (cls)
      CLS_A:   in_window = win_open[0];
      CLS_B:   in_window = win_open[1];
      CLS_C:   in_window = win_open[2];
      default: in_window = 1'b1;
    endcase
  end

  assign bad_req = req_valid & ~in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= 1'b0;
      reject    <= 1'b0;
      viol_flag <= 1'b0;
    end else begin
      grant  <= req_valid & in_window;
      reject <= bad_req;
      if (bad_req)
        viol_flag <= 1'b1;
      else if (viol_rd)
        viol_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/nda_access_window.sv
module nda_access_window
  import nda_win_pkg::*;
#(
  parameter int CLK_KHZ  = 2048,
  parameter int WIN_A_NS = 124750,
  parameter int WIN_B_NS = 109300,
  parameter int WIN_C_NS = 62500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_pulse,
  input  logic                irq_en,
  input  logic                req_valid,
  input  logic [1:0]          req_class,
  input  logic                viol_rd,
  output logic                nda_irq,
  output logic [NUM_SYNC-1:0] win_open,
  output logic                grant,
  output logic                reject,
  output logic                viol_flag
);

  localparam int LEN_A   = ns_to_cycles(WIN_A_NS, CLK_KHZ);
  localparam int LEN_B   = ns_to_cycles(WIN_B_NS, CLK_KHZ);
  localparam int LEN_C   = ns_to_cycles(WIN_C_NS, CLK_KHZ);
  localparam int LEN_MAX = max3(LEN_A, LEN_B, LEN_C);
  localparam int CNT_W   = bits_for(LEN_MAX);
  localparam logic [NUM_SYNC*CNT_W-1:0] LENS =
    {CNT_W'(LEN_C), CNT_W'(LEN_B), CNT_W'(LEN_A)};

  logic             frame_strobe;
  logic [CNT_W-1:0] frame_cnt;
  logic             in_window;

  nda_frame_timer #(
    .CNT_W     (CNT_W),
    .CNT_LIMIT (LEN_MAX)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_pulse  (frame_pulse),
    .frame_strobe (frame_strobe),
    .frame_cnt    (frame_cnt)
  );

  nda_window_decode #(
    .CNT_W (CNT_W),
    .NUM   (NUM_SYNC),
    .LENS  (LENS)
  ) u_decode (
    .frame_cnt (frame_cnt),
    .win_open  (win_open)
  );

  nda_access_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_class (req_class),
    .viol_rd   (viol_rd),
    .win_open  (win_open),
    .in_window (in_window),
    .grant     (grant),
    .reject    (reject),
    .viol_flag (viol_flag)
  );

  assign nda_irq = frame_strobe & irq_en;

endmodule

// File: rtl/nda_access_window_chk.sv
module nda_access_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_en,
  input logic       req_valid,
  input logic [1:0] req_class,
  input logic       viol_rd,
  input logic       nda_irq,
  input logic [2:0] win_open,
  input logic       grant,
  input logic       reject,
  input logic       viol_flag,
  input logic       frame_strobe
);

  p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !nda_irq);

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe);

  p_strobe_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (win_open == 3'b111));

  p_c_inside_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_open[2] |-> win_open[1]);

  p_b_inside_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_open[1] |-> win_open[0]);

  p_resp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));

  p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant || reject));

  p_no_idle_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant && !reject));

  p_async_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'b00) |=> grant);

  p_closed_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'b01 && !win_open[0]) |=> reject);

  p_viol_on_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> viol_flag);

  p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_rd) |=> viol_flag);

endmodule

bind nda_access_window nda_access_window_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_en       (irq_en),
  .req_valid    (req_valid),
  .req_class    (req_class),
  .viol_rd      (viol_rd),
  .nda_irq      (nda_irq),
  .win_open     (win_open),
  .grant        (grant),
  .reject       (reject),
  .viol_flag    (viol_flag),
  .frame_strobe (frame_strobe)
);

// File: tb/nda_access_window_tb.sv
`timescale 1ns/1ps
module nda_access_window_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic       irq_en = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_class = 2'b00;
  logic       viol_rd = 1'b0;
  logic       nda_irq;
  logic [2:0] win_open;
  logic       grant, reject, viol_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  nda_access_window u_dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .irq_en(irq_en),
    .req_valid(req_valid), .req_class(req_class), .viol_rd(viol_rd),
    .nda_irq(nda_irq), .win_open(win_open), .grant(grant),
    .reject(reject), .viol_flag(viol_flag)
  );

  // Window lengths from the time limits at 2.048 MHz, done in real arithmetic.
  int len_a, len_b, len_c;
  initial begin
    len_a = int'($floor(124.75 * 2.048));
    len_b = int'($floor(109.3 * 2.048));
    len_c = int'($floor(62.5 * 2.048));
  end

  // Behavioural frame model.
  int m_since = -1;
  bit m_strobe = 0, m_fpq = 0, m_grant = 0, m_rej = 0, m_viol = 0;

  function automatic bit m_open(int idx);
    int l;
    l = (idx == 0) ? len_a : (idx == 1) ? len_b : len_c;
    return (m_since >= 0) && (m_since < l);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_since = -1; m_strobe = 0; m_fpq = 0;
      m_grant = 0; m_rej = 0; m_viol = 0;
    end else begin
      bit ok, rise;
      rise = frame_pulse && !m_fpq;
      ok = (req_class == 2'b00) || m_open(int'(req_class) - 1);
      m_grant = req_valid && ok;
      m_rej = req_valid && !ok;
      if (m_rej) m_viol = 1;
      else if (viol_rd) m_viol = 0;
      m_strobe = rise;
      if (rise) m_since = 0;
      else if (m_since >= 0 && m_since < 100000) m_since = m_since + 1;
      m_fpq = frame_pulse;
    end
  end

  task automatic chk(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [2:0] ew;
      ew = {m_open(2), m_open(1), m_open(0)};
      chk(nda_irq == (m_strobe && irq_en), "R2/R3 nda_irq", int'(nda_irq), int'(m_strobe && irq_en));
      chk(win_open == ew, "R4/R5/R6 win_open", int'(win_open), int'(ew));
      chk(grant == m_grant, "R8/R9 grant", int'(grant), int'(m_grant));
      chk(reject == m_rej, "R9/R11 reject", int'(reject), int'(m_rej));
      chk(viol_flag == m_viol, "R10 viol_flag", int'(viol_flag), int'(m_viol));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Pulse sampled at the next edge; returns inside the strobe cycle.
  task automatic pulse();
    frame_pulse = 1'b1; tick(); frame_pulse = 1'b0;
  endtask

  // Runs one frame from the strobe cycle, issuing boundary requests and
  // counting open cycles of each window and interrupt pulses.
  task automatic run_frame(int ncyc, output int oa, output int ob, output int oc, output int nirq);
    oa = 0; ob = 0; oc = 0; nirq = 0;
    for (int t = 0; t < ncyc; t++) begin
      req_valid = 1'b0; req_class = 2'b00; viol_rd = 1'b0;
      case (t)
        len_c - 1: begin req_valid = 1; req_class = 2'b11; end
        len_c:     begin req_valid = 1; req_class = 2'b11; end
        len_c + 2: viol_rd = 1;
        len_b - 1: begin req_valid = 1; req_class = 2'b10; end
        len_b:     begin req_valid = 1; req_class = 2'b10; end
        len_a - 1: begin req_valid = 1; req_class = 2'b01; end
        len_a:     begin req_valid = 1; req_class = 2'b01; viol_rd = 1; end
        len_a + 3: begin req_valid = 1; req_class = 2'b00; end
        default: ;
      endcase
      @(negedge clk);
      if (win_open[0]) oa++;
      if (win_open[1]) ob++;
      if (win_open[2]) oc++;
      if (nda_irq) nirq++;
      tick();
    end
    req_valid = 1'b0; viol_rd = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int a, b, c, n;
    repeat (3) tick();
    @(negedge clk);
    // R1: reset state
    chk({nda_irq, win_open, grant, reject, viol_flag} == 7'd0, "R1 reset",
        int'({nda_irq, win_open, grant, reject, viol_flag}), 0);
    tick(); rst_n = 1'b1; cmp_on = 1'b1;
    tick(); tick();
    @(negedge clk);
    chk(win_open == 3'b000, "R1 idle after reset", int'(win_open), 0);
    tick();

    // R8/R9: before any frame, async granted and class A rejected
    req_valid = 1; req_class = 2'b00; tick();
    @(negedge clk); chk(grant == 1'b1, "R8 async no frame", int'(grant), 1); tick();
    req_class = 2'b01; tick();
    @(negedge clk); chk(reject == 1'b1, "R9 class A no frame", int'(reject), 1);
    chk(viol_flag == 1'b1, "R10 set on reject", int'(viol_flag), 1);
    tick(); req_valid = 0; viol_rd = 1; tick(); viol_rd = 0;
    @(negedge clk); chk(viol_flag == 1'b0, "R10 cleared by read", int'(viol_flag), 0);
    tick();

    // Frame with interrupt enabled
    irq_en = 1'b1;
    pulse();
    run_frame(300, a, b, c, n);
    chk(a == len_a, "R4 window A length", a, len_a);
    chk(b == len_b, "R5 window B length", b, len_b);
    chk(c == len_c, "R6 window C length", c, len_c);
    chk(n == 1, "R2 one strobe", n, 1);

    // Frame with interrupt disabled
    irq_en = 1'b0;
    pulse();
    run_frame(300, a, b, c, n);
    chk(n == 0, "R3 irq disabled", n, 0);
    chk(a == len_a, "R3 windows still open", a, len_a);

    // R7: restart mid-window
    irq_en = 1'b1;
    pulse();
    repeat (49) tick();
    pulse();
    run_frame(300, a, b, c, n);
    chk(a == len_a, "R7 restart window A", a, len_a);
    chk(n == 1, "R7 restart strobe", n, 1);

    // R7: pulse held high for several cycles gives one strobe
    frame_pulse = 1'b1;
    n = 0;
    for (int t = 0; t < 12; t++) begin
      @(negedge clk); if (nda_irq) n++;
      tick();
    end
    frame_pulse = 1'b0;
    repeat (4) begin @(negedge clk); if (nda_irq) n++; tick(); end
    chk(n == 1, "R7 held pulse single strobe", n, 1);

    // R10: reject and read in the same cycle keep the flag set
    repeat (300) tick();
    req_valid = 1; req_class = 2'b10; viol_rd = 1; tick();
    req_valid = 0; viol_rd = 0;
    @(negedge clk); chk(viol_flag == 1'b1, "R10 set wins over read", int'(viol_flag), 1);
    chk(reject == 1'b1, "R11 reject pulse", int'(reject), 1);
    tick();
    @(negedge clk); chk(reject == 1'b0, "R11 one-cycle reject", int'(reject), 0);
    tick();

    done = 1'b1;
    summary();
  end

endmodule